// File: doc/BRIEF.md
# Double-Buffered SPI Master

A byte-wide SPI master that clocks eight-bit frames, most significant bit first, over a serial clock, a data-out line and a data-in line. The serial clock rate comes from a 4-bit divider. Clock polarity and phase are chosen by two mode inputs, so all four standard SPI modes are available. Chip select is not generated here; the user drives it around the frames.

The transmit path has one buffer byte in front of the shift register. A byte written while a frame is in flight waits in that buffer. It is moved into the shifter on the very edge that ends the current frame, so consecutive frames stream with an unbroken serial clock. The receive path has a single holding byte with a full flag. A read strobe clears the flag. If a frame completes while the flag is still set, the new byte is dropped, the flag stays set, and the held byte is kept.

Typical use: write a byte when `tx_empty_o` is high, then wait for `rx_full_o` and pulse `rx_rd_i` to take the byte clocked in. For full-rate output-only streaming, write a new byte each time `tx_empty_o` rises.

Top module: `spi_dbuf_master`

## Requirements
- R1: After reset `tx_empty_o`=1, `rx_full_o`=0, `busy_o`=0, `rx_data_o`=0 and `sck_o` equals `cpol_i`.
- R2: A `tx_wr_i` pulse while `tx_empty_o`=1 stores `tx_data_i`, and `tx_empty_o` is 0 on the next cycle. A `tx_wr_i` pulse while `tx_empty_o`=0 is ignored, and that byte never appears on `mosi_o`.
- R3: A buffered byte enters the shifter on the cycle the running frame ends. Serial clock edges then keep an equal spacing of `div_i`+1 cycles across the frame boundary, so the second frame completes exactly 16·(`div_i`+1) cycles after the first.
- R4: Each half-period of `sck_o` lasts `div_i`+1 system clock cycles. Whenever `busy_o`=0, `sck_o` equals `cpol_i`.
- R5: Bits are sent and received most significant bit first. With `cpha_i`=0, `mosi_o` shows bit 7 before the first clock edge; `miso_i` is sampled on the odd-numbered edges (1st, 3rd, …) and `mosi_o` changes on the even-numbered ones. With `cpha_i`=1, `mosi_o` changes on the odd-numbered edges and `miso_i` is sampled on the even-numbered ones.
- R6: When the block is idle and the buffer is empty, a byte written at clock edge t is placed in `rx_data_o`, with `rx_full_o`=1, at edge t+1+16·(`div_i`+1).
- R7: A `rx_rd_i` pulse while `rx_full_o`=1 clears `rx_full_o` on the next cycle.
- R8: A frame that completes while `rx_full_o`=1 is discarded. `rx_full_o` stays 1, `rx_data_o` keeps the earlier byte, and no new rising edge of `rx_full_o` follows after the read.
- R9: `busy_o` is 1 while the shifter is active or the transmit buffer holds a byte, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | 0: sample on the first edge of each bit, 1: sample on the second |
| div_i | input | 4 | Serial clock half-period minus one, in system clocks |
| tx_data_i | input | 8 | Byte to transmit |
| tx_wr_i | input | 1 | Write strobe for the transmit buffer |
| rx_rd_i | input | 1 | Read strobe, clears the receive-full flag |
| rx_data_o | output | 8 | Last accepted received byte |
| tx_empty_o | output | 1 | Transmit buffer can take a byte |
| rx_full_o | output | 1 | Receive byte waiting |
| busy_o | output | 1 | Frame in progress or byte buffered |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
Each result has a fixed due cycle. `tx_empty_o` drops one cycle after an accepted write. The first serial edge follows 1+(`div_i`+1) cycles later. `rx_full_o` rises 1+16·(`div_i`+1) cycles after the write, a streamed second byte lands a further 16·(`div_i`+1) cycles on, and a read clears the flag one cycle after its strobe. The bench counts system clock edges from each stimulus and compares the count at which the result appears with these sums. A slave model watches every serial clock edge on the falling system clock edge, checks that the spacing equals `div_i`+1 and launches its own bits per mode. It samples outputs only at falling edges, and waits one more falling edge before it reads the captured frame, so that the last serial edge has been seen.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;

  typedef struct packed {
    logic cpol;
    logic cpha;
  } spi_mode_t;

  // even edge index = first edge of a bit; cpha=0 samples there
  function automatic logic is_sample_edge(input logic cpha, input logic edge_lsb);
    return edge_lsb == cpha;
  endfunction

endpackage

// File: rtl/spi_dbuf_clkdiv.sv
module spi_dbuf_clkdiv #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || tick_o)   cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/spi_dbuf_txbuf.sv
module spi_dbuf_txbuf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else if (take_i) begin
      full_o <= 1'b0;
    end else if (wr_i && !full_o) begin
      full_o <= 1'b1;
      data_o <= data_i;
    end
  end

endmodule

// File: rtl/spi_dbuf_rxbuf.sv
module spi_dbuf_rxbuf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              rd_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);

  // a frame ending while full is dropped; the held byte survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else if (full_o) begin
      if (rd_i) full_o <= 1'b0;
    end else if (done_i) begin
      full_o <= 1'b1;
      data_o <= byte_i;
    end
  end

endmodule

// File: rtl/spi_dbuf_shifter.sv
module spi_dbuf_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpha_i,
  input  logic              miso_i,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic              active_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              sck_ph_o,
  output logic              mosi_o
);

  localparam int unsigned EDGES  = 2 * DATA_W;
  localparam int unsigned EDGE_W = $clog2(EDGES);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

  logic [EDGE_W-1:0] edge_q;
  logic [DATA_W-1:0] txs_q, rxs_q;
  logic              smp;

  assign smp       = spi_dbuf_pkg::is_sample_edge(cpha_i, edge_q[0]);
  assign done_o    = active_o && tick_i && (edge_q == LAST_EDGE);
  // with cpha=1 the last sample coincides with the final edge
  assign rx_byte_o = cpha_i ? {rxs_q[DATA_W-2:0], miso_i} : rxs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      edge_q   <= '0;
      sck_ph_o <= 1'b0;
      mosi_o   <= 1'b0;
      txs_q    <= '0;
      rxs_q    <= '0;
    end else if (load_i) begin
      active_o <= 1'b1;
      edge_q   <= '0;
      sck_ph_o <= 1'b0;
      if (cpha_i) begin
        txs_q <= load_data_i;
      end else begin
        mosi_o <= load_data_i[DATA_W-1];
        txs_q  <= {load_data_i[DATA_W-2:0], 1'b0};
      end
    end else if (done_o) begin
      active_o <= 1'b0;
      edge_q   <= '0;
      sck_ph_o <= 1'b0;
    end else if (active_o && tick_i) begin
      edge_q   <= edge_q + 1'b1;
      sck_ph_o <= ~sck_ph_o;
      if (smp) begin
        rxs_q <= {rxs_q[DATA_W-2:0], miso_i};
      end else begin
        mosi_o <= txs_q[DATA_W-1];
        txs_q  <= {txs_q[DATA_W-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_wr_i,
  input  logic              rx_rd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              tx_empty_o,
  output logic              rx_full_o,
  output logic              busy_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i
);

  spi_dbuf_pkg::spi_mode_t mode;
  logic              tick, active, done, load, tx_full, sck_ph;
  logic [DATA_W-1:0] tx_byte, rx_byte;

  assign mode = '{cpol: cpol_i, cpha: cpha_i};
  // idle: take at once; running: take on the closing edge, no gap
  assign load = tx_full && (!active || done);

  spi_dbuf_clkdiv #(.DIV_W(DIV_W)) i_clkdiv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (active),
    .div_i  (div_i),
    .tick_o (tick)
  );

  spi_dbuf_txbuf #(.DATA_W(DATA_W)) i_txbuf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (tx_wr_i),
    .data_i (tx_data_i),
    .take_i (load),
    .full_o (tx_full),
    .data_o (tx_byte)
  );

  spi_dbuf_shifter #(.DATA_W(DATA_W)) i_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpha_i      (mode.cpha),
    .miso_i      (miso_i),
    .tick_i      (tick),
    .load_i      (load),
    .load_data_i (tx_byte),
    .active_o    (active),
    .done_o      (done),
    .rx_byte_o   (rx_byte),
    .sck_ph_o    (sck_ph),
    .mosi_o      (mosi_o)
  );

  spi_dbuf_rxbuf #(.DATA_W(DATA_W)) i_rxbuf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_i (done),
    .byte_i (rx_byte),
    .rd_i   (rx_rd_i),
    .full_o (rx_full_o),
    .data_o (rx_data_o)
  );

  assign sck_o      = mode.cpol ^ sck_ph;
  assign busy_o     = active | tx_full;
  assign tx_empty_o = ~tx_full;

endmodule

// File: rtl/spi_dbuf_master_chk.sv
module spi_dbuf_master_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpol_i,
  input logic              cpha_i,
  input logic [DIV_W-1:0]  div_i,
  input logic [DATA_W-1:0] tx_data_i,
  input logic              tx_wr_i,
  input logic              rx_rd_i,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              tx_empty_o,
  input logic              rx_full_o,
  input logic              busy_o,
  input logic              sck_o,
  input logic              mosi_o,
  input logic              miso_i
);

  // R2
  tx_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr_i && tx_empty_o |=> !tx_empty_o);

  // R9
  busy_buf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_empty_o |-> busy_o);

  // R4
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> sck_o == cpol_i);

  // R7
  rx_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rd_i && rx_full_o |=> !rx_full_o);

  // R8
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full_o && !rx_rd_i |=> rx_full_o && $stable(rx_data_o));

  // R6
  rx_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_full_o) |-> $past(busy_o));

endmodule

bind spi_dbuf_master spi_dbuf_master_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) i_chk (.*);

// File: tb/test_spi_dbuf_master.sv
module test_spi_dbuf_master;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       cpol = 1'b0, cpha = 1'b0;
  logic [3:0] divv = '0;
  logic [7:0] tx_data = '0;
  logic       tx_wr = 1'b0, rx_rd = 1'b0;
  logic [7:0] rx_data_o;
  logic       tx_empty_o, rx_full_o, busy_o, sck_o, mosi_o;
  logic       miso = 1'b0;

  always #10 clk_i = ~clk_i;

  spi_dbuf_master i_spi_dbuf_master (
    .clk_i(clk_i), .rst_ni(rst_ni), .cpol_i(cpol), .cpha_i(cpha), .div_i(divv),
    .tx_data_i(tx_data), .tx_wr_i(tx_wr), .rx_rd_i(rx_rd), .rx_data_o(rx_data_o),
    .tx_empty_o(tx_empty_o), .rx_full_o(rx_full_o), .busy_o(busy_o),
    .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso)
  );

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sb(input int base, input int k);
    return 8'((base + k * 61) ^ 'h96);
  endfunction

  // slave model
  int         arm_cnt = 0, seen_arm = 0, s_base = 0;
  int         s_idx = 0, s_k = 0, ncap = 0, last_cyc = 0, gap_seen = 0, gap_bad = 0;
  logic [7:0] sbyte = '0, m_rx = '0;
  logic [7:0] cap [0:7];
  logic       prev_sck = 1'b0, busy_prev = 1'b0;
  bit         have_prev = 0;

  always @(negedge clk_i) begin
    if (arm_cnt != seen_arm) begin
      seen_arm = arm_cnt;
      s_idx = 0; s_k = 0; ncap = 0; m_rx = '0;
      sbyte = sb(s_base, 0);
      miso = sbyte[7];
    end else if (busy_prev && sck_o !== prev_sck) begin
      if (have_prev) begin
        gap_seen++;
        if (cyc - last_cyc != int'(divv) + 1) gap_bad++;
      end
      have_prev = 1;
      last_cyc = cyc;
      if (s_idx[0] == cpha) m_rx = {m_rx[6:0], mosi_o};
      else if (cpha) miso = sbyte[7 - s_idx / 2];
      else if (s_idx < 15) miso = sbyte[7 - (s_idx / 2 + 1)];
      s_idx++;
      if (s_idx == 16) begin
        cap[ncap % 8] = m_rx;
        ncap++;
        s_idx = 0;
        s_k++;
        sbyte = sb(s_base, s_k);
        if (!cpha) miso = sbyte[7];
      end
    end
    if (!busy_prev) have_prev = 0;
    prev_sck = sck_o;
    busy_prev = busy_o;
  end

  task automatic arm(input int base);
    s_base = base;
    arm_cnt++;
    @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr_byte(input logic [7:0] d);
    tx_data = d;
    tx_wr = 1'b1;
    @(negedge clk_i);
    tx_wr = 1'b0;
  endtask

  task automatic rd_byte(output logic [7:0] d);
    d = rx_data_o;
    rx_rd = 1'b1;
    @(negedge clk_i);
    rx_rd = 1'b0;
  endtask

  task automatic wait_rx(output int n);
    n = 0;
    while (!rx_full_o && n < 5000) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    logic [7:0] d, ta, tb;
    int n, c0, dl;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 tx_empty", tx_empty_o, 1);
    chk("R1 rx_full", rx_full_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 sck", sck_o, 0);
    chk("R1 rx_data", rx_data_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // single frames: all modes, several dividers
    for (int m = 0; m < 4; m++) begin
      for (int di = 0; di < 5; di++) begin
        int dv;
        dv = (di == 0) ? 0 : (di == 1) ? 1 : (di == 2) ? 2 : (di == 3) ? 5 : 15;
        cpol = m[1]; cpha = m[0]; divv = 4'(dv);
        for (int j = 0; j < 3; j++) begin
          ta = 8'(m * 37 + dv * 11 + j * 89 + 5);
          arm(m * 16 + dv + j * 3);
          chk("R4 idle sck", sck_o, cpol);
          wr_byte(ta);
          chk("R2 tx_empty low after write", tx_empty_o, 0);
          chk("R9 busy with byte buffered", busy_o, 1);
          wait_rx(n);
          chk("R6 latency", n, 1 + 16 * (dv + 1));
          chk("R5 rx byte", rx_data_o, sb(s_base, 0));
          @(negedge clk_i);
          chk("R5 mosi byte", cap[0], ta);
          chk("R9 busy idle", busy_o, 0);
          chk("R4 idle sck after frame", sck_o, cpol);
          rd_byte(d);
          chk("R7 rx_full cleared", rx_full_o, 0);
        end
      end
    end

    // streamed frames with an ignored write
    for (int m = 0; m < 4; m++) begin
      for (int di = 0; di < 2; di++) begin
        int dv;
        dv = di * 3;
        cpol = m[1]; cpha = m[0]; divv = 4'(dv);
        dl = 1 + 16 * (dv + 1);
        ta = 8'(m * 53 + 17); tb = 8'(~ta + 8'(dv));
        arm(100 + m * 7 + dv);
        wr_byte(ta);
        c0 = cyc;
        @(negedge clk_i);
        chk("R2 buffer free once loaded", tx_empty_o, 1);
        wr_byte(tb);
        wr_byte(8'h5A);
        wait_rx(n);
        chk("R6 first frame time", cyc - c0, dl);
        rd_byte(d);
        chk("R5 first stream byte", d, sb(s_base, 0));
        wait_rx(n);
        chk("R3 no gap second frame time", cyc - c0, dl + 16 * (dv + 1));
        rd_byte(d);
        chk("R3 second stream byte", d, sb(s_base, 1));
        @(negedge clk_i);
        @(negedge clk_i);
        chk("R2 ignored write not sent", ncap, 2);
        chk("R3 mosi first", cap[0], ta);
        chk("R3 mosi second", cap[1], tb);
        chk("R9 busy after stream", busy_o, 0);
      end
    end

    // overrun
    cpol = 1'b0; cpha = 1'b1; divv = 4'd1;
    arm(211);
    wr_byte(8'h3C);
    @(negedge clk_i);
    wr_byte(8'hC3);
    while (busy_o) @(negedge clk_i);
    @(negedge clk_i);
    chk("R8 both frames sent", ncap, 2);
    chk("R8 rx_full stays", rx_full_o, 1);
    chk("R8 older byte kept", rx_data_o, sb(211, 0));
    rd_byte(d);
    chk("R8 read returns older byte", d, sb(211, 0));
    chk("R7 cleared by read", rx_full_o, 0);
    repeat (6) @(negedge clk_i);
    chk("R8 no new full event", rx_full_o, 0);
    chk("R8 data unchanged", rx_data_o, sb(211, 0));

    chk("R4 edges observed", (gap_seen > 100) ? 1 : 0, 1);
    chk("R4 half-period spacing", gap_bad, 0);
    finish_run();
  end

endmodule